// File: doc/BRIEF.md
# Glitch-Free Divide-by-16 Clock Generator

This block takes a fast input clock and produces a slower clock whose period is sixteen input cycles. In each period the output is high for twelve input cycles and low for four, a 75% duty cycle. The result is meant to clock other logic, so the output comes straight from a flip-flop. It never passes through combinational gates, and so it cannot glitch between input edges.

A phase counter steps through sixteen positions and wraps. Two registers are loaded from the counter's next value: one holds the divided clock, the other holds a one-cycle marker. The marker is high in the input cycle where a new output period begins.

Reset is synchronous to the input clock. While reset is sampled low at an input edge, the counter returns to phase 0 with the output high and the marker set. The first full period then runs from the next edge onwards.

Top module: `clkdiv16_gf`

## Requirements
- R1: Successive rising edges of `clk_out` are exactly DIV_RATIO (default 16) input clock cycles apart.
- R2: Within every output period, `clk_out` is high for HIGH_CYCLES (default 12) input cycles and low for the remaining DIV_RATIO-HIGH_CYCLES (default 4) cycles.
- R3: `clk_out` is a flip-flop output: it changes only just after a rising edge of `clk_in` and holds its value for the rest of that input cycle.
- R4: Reset is synchronous and active low. When `rst_n` is sampled low at an input edge, the next state is phase 0, with `clk_out` high and `period_start` high. Lowering `rst_n` between edges changes no output before the next edge.
- R5: After reset is released, the k-th input edge puts the block in phase k mod DIV_RATIO. `clk_out` is high when that phase is below HIGH_CYCLES and low otherwise.
- R6: `period_start` is high for exactly one input cycle per period, namely the cycle in which the phase is 0. It therefore coincides with each rising edge of `clk_out`.
- R7: The phase counter wraps from DIV_RATIO-1 back to 0, and otherwise increases by one on every input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_out | output | 1 | Divided clock, 12 of 16 cycles high, registered |
| period_start | output | 1 | Registered one-cycle pulse at phase 0 of each period |

## Verification
The bench builds the block with its default values, a ratio of 16 and a high time of 12. With these values the 4-bit phase counter runs through its full range and wraps at its natural binary limit, and the falling edge falls at a phase that is not a power of two. A reset is applied in the middle of a run while the output is low. This shows that the output holds until the next edge and then jumps straight to a high phase-0 state, which truncates the current period. Each period's spacing and high time are measured separately from the per-cycle phase comparison.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Phase that follows cur in a modulo-div sequence.
  function automatic int unsigned phase_after(input int unsigned cur, input int unsigned div);
    return (cur >= div - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/clkdiv_phase_ctr.sv
module clkdiv_phase_ctr
  import clkdiv_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 16,
  localparam int unsigned PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nxt
);

  // Next-state logic; the synchronous reset is folded in here.
  always_comb begin
    if (!rst_n) begin
      phase_nxt = '0;
    end else if (adv_en) begin
      phase_nxt = PW'(phase_after(int'(phase_q), DIV_RATIO));
    end else begin
      phase_nxt = phase_q;
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_nxt;
  end

  // R7: wrap at the last phase
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && adv_en && phase_q == PW'(DIV_RATIO - 1)) |=> (phase_q == '0));

  // R7: single step otherwise
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && adv_en && phase_q < PW'(DIV_RATIO - 1)) |=> (phase_q == $past(phase_q) + 1'b1));

endmodule

// File: rtl/clkdiv_shaper.sv
module clkdiv_shaper #(
  parameter int unsigned DIV_RATIO   = 16,
  parameter int unsigned HIGH_CYCLES = 12,
  localparam int unsigned PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_q,
  input  logic [PW-1:0] phase_nxt,
  output logic          clk_div_q
);

  localparam logic [PW-1:0] EDGE_FALL = PW'(HIGH_CYCLES);

  logic level_nxt;

  // The output level is decided from the phase about to be entered,
  // so that the flop lines up with the counter.
  always_comb begin
    level_nxt = (phase_nxt < EDGE_FALL);
  end

  always_ff @(posedge clk) begin
    clk_div_q <= level_nxt;
  end

  // R2: a falling edge happens only on entering the fall phase
  p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_div_q) |-> (phase_q == EDGE_FALL));

  // R3: no change of the output away from the two edge phases
  p_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && phase_q != '0 && phase_q != EDGE_FALL) |-> $stable(clk_div_q));

endmodule

// File: rtl/clkdiv_marker.sv
module clkdiv_marker #(
  parameter int unsigned DIV_RATIO = 16,
  localparam int unsigned PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_q,
  input  logic [PW-1:0] phase_nxt,
  output logic          mark_q
);

  logic mark_nxt;

  always_comb begin
    mark_nxt = (phase_nxt == '0);
  end

  always_ff @(posedge clk) begin
    mark_q <= mark_nxt;
  end

  // R6: the pulse lasts one cycle
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mark_q) |=> !mark_q);

  // R6: the pulse coincides with phase 0
  p_phase0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && mark_q) |-> (phase_q == '0));

endmodule

// File: rtl/clkdiv16_gf.sv
module clkdiv16_gf #(
  parameter int unsigned DIV_RATIO   = 16,
  parameter int unsigned HIGH_CYCLES = 12
) (
  input  logic clk_in,
  input  logic rst_n,
  output logic clk_out,
  output logic period_start
);

  localparam int unsigned PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;
  logic          adv_en;

  // The counter advances on every input edge.
  assign adv_en = 1'b1;

  clkdiv_phase_ctr #(.DIV_RATIO(DIV_RATIO)) u_ctr (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .adv_en    (adv_en),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt)
  );

  clkdiv_shaper #(.DIV_RATIO(DIV_RATIO), .HIGH_CYCLES(HIGH_CYCLES)) u_shape (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .clk_div_q (clk_out)
  );

  clkdiv_marker #(.DIV_RATIO(DIV_RATIO)) u_mark (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .mark_q    (period_start)
  );

  // R4: reset sampled low leads to phase 0, output high, marker set
  p_reset_r4: assert property (@(posedge clk_in)
    !rst_n |=> (clk_out && period_start && phase_q == '0));

  // R1: every rising edge of the output starts a period
  p_rise_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (rst_n && $past(rst_n) && $rose(clk_out)) |-> period_start);

endmodule

// File: tb/clkdiv16_gf_test.sv
module clkdiv16_gf_test;

  localparam int DIV  = 16;
  localparam int HIGH = 12;

  logic clk_in = 1'b0;
  logic rst_n  = 1'b0;
  logic clk_out;
  logic period_start;

  int total = 0;
  int bad   = 0;

  int model_ph   = 0;
  int cyc        = 0;
  int last_rise  = -1;
  int high_cnt   = 0;
  logic prev_out = 1'b0;
  logic post_edge_samp;
  logic checking = 1'b0;

  always #2 clk_in = ~clk_in;

  clkdiv16_gf #(.DIV_RATIO(DIV), .HIGH_CYCLES(HIGH)) uut (
    .clk_in       (clk_in),
    .rst_n        (rst_n),
    .clk_out      (clk_out),
    .period_start (period_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase integer stepped at each input edge.
  always @(posedge clk_in) begin
    if (!rst_n) model_ph <= 0;
    else        model_ph <= (model_ph + 1) % DIV;
    cyc <= cyc + 1;
  end

  always @(posedge clk_in) begin
    #1 post_edge_samp = clk_out;
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk_in) begin
    if (checking) begin
      chk(clk_out === (model_ph < HIGH), "R5 level", int'(clk_out), int'(model_ph < HIGH));
      chk(period_start === (model_ph == 0), "R6 marker", int'(period_start), int'(model_ph == 0));
      chk(clk_out === post_edge_samp, "R3 held within cycle", int'(clk_out), int'(post_edge_samp));
      if (rst_n) begin
        if (clk_out && !prev_out) begin
          if (last_rise >= 0)
            chk(cyc - last_rise == DIV, "R1 rise spacing", cyc - last_rise, DIV);
          last_rise = cyc;
        end
        if (period_start && cyc > 0 && model_ph == 0 && last_rise >= 0 && high_cnt > 0 && cyc - last_rise == 0) begin
          if (high_cnt != 0 && total > 4) chk(high_cnt == HIGH, "R2 high time", high_cnt, HIGH);
          high_cnt = 0;
        end
        if (clk_out) high_cnt++;
      end else begin
        last_rise = -1;
        high_cnt  = 0;
      end
      prev_out = clk_out;
    end
  end

  initial begin
    repeat (3) @(negedge clk_in);
    checking = 1'b1;
    // R4: reset state
    chk(clk_out === 1'b1, "R4 reset level", int'(clk_out), 1);
    chk(period_start === 1'b1, "R4 reset marker", int'(period_start), 1);
    rst_n = 1'b1;
    // R7: run several full periods across the wrap
    repeat (5 * DIV + 13) @(negedge clk_in);
    // now at phase 13: output low
    chk(clk_out === 1'b0, "R5 low phase", int'(clk_out), 0);
    rst_n = 1'b0;
    #1;
    // R4: no effect before the next edge
    chk(clk_out === 1'b0, "R4 sync reset no early effect", int'(clk_out), 0);
    chk(period_start === 1'b0, "R4 sync reset marker held", int'(period_start), 0);
    @(negedge clk_in);
    chk(clk_out === 1'b1, "R4 reset forces high", int'(clk_out), 1);
    chk(period_start === 1'b1, "R4 reset forces marker", int'(period_start), 1);
    @(negedge clk_in);
    rst_n = 1'b1;
    repeat (4 * DIV) @(negedge clk_in);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule